// File: doc/BRIEF.md
# Two-Read One-Write Register File with Forwarding and Read Caching

This block is the register storage of a scalar pipelined core. It has one write port and two independent read ports. Each read port returns its result one clock after the address is presented. A register written in a given cycle can be read back in that same cycle: the read port compares its address with the write address and passes the incoming write data straight to its output, without using the stored copy.

The write address is decoded into a one-hot row select. That select is captured in a register together with the data, and only the registered select drives the array. A change on the address lines therefore cannot disturb a row, and a write lands one edge after it is presented. A read in the cycle after a write compares against this staged write, so the delay is never visible at the ports.

Each read port keeps the address and value of its last read. When the port asks for the same address again, the array is not read and the kept value is returned. A per-port flag reports whether the value now on the output came from the array. A test environment can use the flag to count the array accesses that were saved.

Top module: `regfile_2r1w_fwd`

## Requirements
- R1: While `rst` is high at a rising edge, every row, both outputs and both array flags are cleared to zero at that edge, and both read ports forget their last address.
- R2: A read port that is given an address in cycle t presents that row's current contents on its data output after the edge that ends cycle t, and holds it for the whole of cycle t+1.
- R3: The two read ports work independently, and each may read any row in the same cycle as the other, including the same row.
- R4: If `wr_en` is high and the write address equals a port's read address in the same cycle, that port returns `wr_data` from that cycle, and its array flag is 0.
- R5: A write presented in cycle t can be read back in cycle t+1 and in every later cycle, until another write to the same row replaces it.
- R6: With `wr_en` low, no row changes, whatever values `wr_addr` and `wr_data` carry.
- R7: If a port's read address equals the address it read in the previous cycle, and no reset came between the two reads, the array is not read. The flag is 0, and the output keeps its previous value unless the same-cycle write of R4 targets that address.
- R8: A read port never returns a value older than the most recent write to the row it reads, including a row it holds as its last read.
- R9: Row 0 stores and returns data like every other row; it is not fixed at zero.
- R10: A port's array flag is 1 only when the value it now presents was read from the array. That means none of these applied: a write in the same cycle, a write in the previous cycle to that address, or a repeated address.
- R11: Each write changes exactly the addressed row and no other row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | AW | Row to write |
| wr_data | input | DW | Data to write |
| rd_addr_a | input | AW | Read address, port A |
| rd_addr_b | input | AW | Read address, port B |
| rd_data_a | output | DW | Registered read result, port A |
| rd_data_b | output | DW | Registered read result, port B |
| arr_rd_a | output | 1 | 1 when `rd_data_a` came from an array read |
| arr_rd_b | output | 1 | 1 when `rd_data_b` came from an array read |

## Verification
The bench reads a row in the same cycle it is written, and again in the cycle after. Without same-cycle forwarding the first read would return the old contents. If the staged write were ignored, the second read would be one cycle stale. It also keeps a port on one address while that row is rewritten, which exposes a read cache that never learns of the write. It also checks the first read after reset, which would wrongly report a repeated address if the cache were not cleared. Writes with `wr_en` low, and writes whose neighbouring rows are read afterwards, catch a decoder that selects the wrong row or more than one. A long run with random traffic confined to a few addresses forces collisions between the two ports, the write, and the previous cycle's write.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Where a read port takes its next output value from
  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_WRITE  = 2'd1,
    SRC_STAGED = 2'd2,
    SRC_CACHE  = 2'd3
  } rd_src_e;

endpackage

// File: rtl/rf_wdecode.sv
module rf_wdecode #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DEPTH-1:0] sel_q,
  output logic             en_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    data_q
);

  logic [DEPTH-1:0] sel_d;

  // full decode; the result is captured before it reaches the rows
  always_comb begin
    for (int r = 0; r < DEPTH; r++) begin
      sel_d[r] = wr_en && (wr_addr == AW'(r));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      en_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sel_q  <= sel_d;
      en_q   <= wr_en;
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

endmodule

// File: rtl/rf_array.sv
module rf_array #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DEPTH-1:0]        sel,
  input  logic [DW-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][DW-1:0]  rdata
);

  localparam logic [AW:0] DEPTH_W = DEPTH[AW:0];

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < DEPTH; r++) mem[r] <= '0;
    end else begin
      for (int r = 0; r < DEPTH; r++) begin
        if (sel[r]) mem[r] <= wdata;
      end
    end
  end

  // asynchronous read, one mux per read port
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = ({1'b0, raddr[p]} < DEPTH_W) ? mem[raddr[p]] : '0;
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          stg_en,
  input  logic [AW-1:0] stg_addr,
  input  logic [DW-1:0] stg_data,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rdata,
  output logic          arr_rd
);

  rd_src_e       src;
  logic [DW-1:0] next_data;
  logic [AW-1:0] tag_q;
  logic          valid_q;
  logic [DW-1:0] rdata_q;
  logic          arr_rd_q;

  // priority: same-cycle write, staged write, repeated address, array
  always_comb begin
    if (wr_en && (wr_addr == raddr))          src = SRC_WRITE;
    else if (stg_en && (stg_addr == raddr))   src = SRC_STAGED;
    else if (valid_q && (tag_q == raddr))     src = SRC_CACHE;
    else                                      src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_WRITE:  next_data = wr_data;
      SRC_STAGED: next_data = stg_data;
      SRC_CACHE:  next_data = rdata_q;
      default:    next_data = arr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      tag_q    <= '0;
      rdata_q  <= '0;
      arr_rd_q <= 1'b0;
    end else begin
      valid_q  <= 1'b1;
      tag_q    <= raddr;
      rdata_q  <= next_data;
      arr_rd_q <= (src == SRC_ARRAY);
    end
  end

  assign rdata  = rdata_q;
  assign arr_rd = arr_rd_q;

endmodule

// File: rtl/regfile_2r1w_fwd.sv
module regfile_2r1w_fwd #(
  parameter int   DEPTH = 32,
  parameter int   DW    = 32,
  localparam int  AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b,
  output logic          arr_rd_a,
  output logic          arr_rd_b
);

  localparam int NRD = 2;

  logic [DEPTH-1:0]       wsel_q;
  logic                   stg_en;
  logic [AW-1:0]          stg_addr;
  logic [DW-1:0]          stg_data;
  logic [NRD-1:0][AW-1:0] raddr;
  logic [NRD-1:0][DW-1:0] arr_data;
  logic [NRD-1:0][DW-1:0] rdata;
  logic [NRD-1:0]         arr_rd;

  assign raddr[0] = rd_addr_a;
  assign raddr[1] = rd_addr_b;

  rf_wdecode #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_wdec (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sel_q   (wsel_q),
    .en_q    (stg_en),
    .addr_q  (stg_addr),
    .data_q  (stg_data)
  );

  rf_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .NRD(NRD)) u_array (
    .clk   (clk),
    .rst   (rst),
    .sel   (wsel_q),
    .wdata (stg_data),
    .raddr (raddr),
    .rdata (arr_data)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_read_port #(.DW(DW), .AW(AW)) u_port (
      .clk      (clk),
      .rst      (rst),
      .raddr    (raddr[p]),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .stg_en   (stg_en),
      .stg_addr (stg_addr),
      .stg_data (stg_data),
      .arr_data (arr_data[p]),
      .rdata    (rdata[p]),
      .arr_rd   (arr_rd[p])
    );
  end

  assign rd_data_a = rdata[0];
  assign rd_data_b = rdata[1];
  assign arr_rd_a  = arr_rd[0];
  assign arr_rd_b  = arr_rd[1];

endmodule

// File: rtl/rf_chk.sv
module rf_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [AW-1:0]    rd_addr_a,
  input logic [AW-1:0]    rd_addr_b,
  input logic [DW-1:0]    rd_data_a,
  input logic [DW-1:0]    rd_data_b,
  input logic             arr_rd_a,
  input logic             arr_rd_b,
  input logic [DEPTH-1:0] wsel
);

  logic          prev_ok;
  logic [AW-1:0] prev_a;
  logic [AW-1:0] prev_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok <= 1'b0;
      prev_a  <= '0;
      prev_b  <= '0;
    end else begin
      prev_ok <= 1'b1;
      prev_a  <= rd_addr_a;
      prev_b  <= rd_addr_b;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0 && !arr_rd_a && !arr_rd_b));

  // R4
  fwd_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == rd_addr_a) |=> (rd_data_a == $past(wr_data) && !arr_rd_a));

  // R4
  fwd_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == rd_addr_b) |=> (rd_data_b == $past(wr_data) && !arr_rd_b));

  // R7
  repeat_a_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && rd_addr_a == prev_a && !(wr_en && wr_addr == rd_addr_a))
      |=> (!arr_rd_a && $stable(rd_data_a)));

  // R7
  repeat_b_chk: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && rd_addr_b == prev_b && !(wr_en && wr_addr == rd_addr_b))
      |=> (!arr_rd_b && $stable(rd_data_b)));

  // R6
  no_write_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (wsel == '0));

  // R11
  one_row_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ($countones(wsel) == 1));

  // R11
  sel_onehot0_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wsel));

endmodule

bind regfile_2r1w_fwd rf_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr_a (rd_addr_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_a (rd_data_a),
  .rd_data_b (rd_data_b),
  .arr_rd_a  (arr_rd_a),
  .arr_rd_b  (arr_rd_b),
  .wsel      (wsel_q)
);

// File: tb/regfile_2r1w_fwd_test.sv
module regfile_2r1w_fwd_test;

  localparam int DEPTH = 32;
  localparam int DW    = 32;
  localparam int AW    = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr_a = '0;
  logic [AW-1:0] rd_addr_b = '0;
  logic [DW-1:0] rd_data_a;
  logic [DW-1:0] rd_data_b;
  logic          arr_rd_a;
  logic          arr_rd_b;

  int checks = 0;
  int errors = 0;

  // reference state: logical contents, last read per port, last write
  logic [DW-1:0] model [DEPTH];
  bit            pv_a, pv_b;
  int            pa, pb;
  bit            lw_en;
  int            lw_addr;
  logic [DW-1:0] exp_a, exp_b;
  bit            exp_ar_a, exp_ar_b;

  always #4 clk = ~clk;

  regfile_2r1w_fwd #(.DEPTH(DEPTH), .DW(DW)) uut (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .arr_rd_a  (arr_rd_a),
    .arr_rd_b  (arr_rd_b)
  );

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < DEPTH; r++) model[r] = '0;
    pv_a = 0; pv_b = 0; pa = 0; pb = 0; lw_en = 0; lw_addr = 0;
  endtask

  // one cycle: drive at negedge, predict at posedge, compare at next negedge
  task automatic step(input bit we, input int wa, input logic [DW-1:0] wd,
                      input int ra, input int rb, input string tag);
    bit fa, fb;
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd_addr_a = AW'(ra); rd_addr_b = AW'(rb);
    @(posedge clk);
    fa = we && (wa == ra);
    fb = we && (wa == rb);
    exp_a = fa ? wd : model[ra];
    exp_b = fb ? wd : model[rb];
    exp_ar_a = !(fa || (lw_en && lw_addr == ra) || (pv_a && pa == ra));
    exp_ar_b = !(fb || (lw_en && lw_addr == rb) || (pv_b && pb == rb));
    pv_a = 1; pa = ra; pv_b = 1; pb = rb;
    if (we) model[wa] = wd;
    lw_en = we; lw_addr = wa;
    @(negedge clk);
    chk(tag, "rd_data_a", rd_data_a, exp_a);
    chk(tag, "rd_data_b", rd_data_b, exp_b);
    chk(tag, "arr_rd_a", {31'b0, arr_rd_a}, {31'b0, exp_ar_a});
    chk(tag, "arr_rd_b", {31'b0, arr_rd_b}, {31'b0, exp_ar_b});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: cleared outputs after reset
    chk("R1", "rd_data_a", rd_data_a, '0);
    chk("R1", "rd_data_b", rd_data_b, '0);
    chk("R1", "arr_rd", {30'b0, arr_rd_a, arr_rd_b}, '0);
    // R1: rows read zero and first read is not a repeat
    step(0, 0, '0, 0, 5, "R1");
    // R4 R9: write row 0 and read it in the same cycle
    step(1, 0, 32'hA5A5_0001, 0, 7, "R4");
    // R7 on port A, R5 staged write seen by port B
    step(0, 0, '0, 0, 0, "R5");
    step(0, 0, '0, 0, 0, "R9");
    // R2 R10: plain array reads
    step(1, 5, 32'h1234_5678, 3, 9, "R10");
    step(0, 0, '0, 5, 5, "R5");
    // R6: write strobe low with row 5 addressed
    step(0, 5, 32'hDEAD_BEEF, 5, 5, "R6");
    step(0, 0, '0, 1, 2, "R6");
    step(0, 0, '0, 5, 5, "R6");
    // R8: rewrite row 12 while port A keeps reading it
    step(0, 0, '0, 12, 3, "R8");
    step(0, 0, '0, 12, 3, "R7");
    step(1, 12, 32'h0C0C_0001, 12, 3, "R8");
    step(0, 0, '0, 12, 3, "R8");
    step(1, 12, 32'h0C0C_0002, 4, 12, "R8");
    step(0, 0, '0, 12, 12, "R8");
    step(0, 0, '0, 12, 12, "R7");
    // R11: only the addressed row changes
    step(1, 20, 32'h2020_2020, 0, 1, "R11");
    step(0, 0, '0, 19, 21, "R11");
    step(0, 0, '0, 20, 31, "R11");
    // R3: both ports on the same row, then random traffic
    step(1, 31, 32'hFFFF_0031, 31, 31, "R3");
    for (int i = 0; i < 3000; i++) begin
      int mask;
      mask = (i % 5 == 0) ? 31 : 7;
      step(($urandom % 2) == 1, int'($urandom) & mask, $urandom,
           int'($urandom) & mask, int'($urandom) & mask, "R3");
    end
    // R1: reset mid-run clears rows and repeat tracking
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1", "rd_data_a", rd_data_a, '0);
    step(0, 0, '0, 31, 31, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule